// File: doc/BRIEF.md
# Two-Channel PWM Action Stage with Buffered Software Override

This block is the output stage of a two-channel pulse-width modulator. A separate time base supplies a prescaled tick and four event strobes: counter at zero, counter at period, compare A matched while counting up, and compare B matched while counting up. Each channel has its own action word. The word says what each event does to that channel's pin: leave it, drive it low, drive it high or toggle it. To get normal polarity, set the pin high at zero and at period and low on the channel's compare event. To get inverted polarity, swap high and low.

A software override sits above the event actions. It can hold either pin low or high. The override is written into a shadow copy. It reaches the active copy at a reload point chosen by a mode field: at zero, at period, at either of them, or at once. Software can therefore start or stop a forced level on a clean PWM boundary. Configuration uses a simple write port with a 2-bit register select.

Top module: `pwm_action_stage`

## Requirements
- R1: Action word layout, as seen on the write port: bits 1:0 set the action at zero, bits 3:2 the action at period, bits 5:4 the action at compare A up, and bits 9:8 the action at compare B up. Bits 7:6 are ignored.
- R2: Action codes are 00 keep, 01 low, 10 high and 11 toggle. Normal polarity (0x01A on A, 0x10A on B) and inverted polarity (0x025 on A) follow from these codes.
- R3: Events change a pin only in a cycle where tick is high. The pin takes its new level at the clock edge that samples the tick.
- R4: Several events on one tick are applied in the order zero, period, compare A, compare B. Each event acts on the result of the one before, so the last one applied wins.
- R5: Force codes per channel are 01 hold low and 10 hold high. Codes 00 and 11 mean no force. While the active force is low or high, each tick drives the forced level and event actions are ignored.
- R6: Reload mode 00, 01 and 10 copy the shadow force into the active force on a tick that carries zero, period, or either one. The copied value already governs the pin on that same tick.
- R7: In reload mode 11 the active force follows the shadow on every clock. A new force value therefore controls the pin from the next tick.
- R8: Write select 0 loads the A action word and select 1 the B action word. Select 2 loads the shadow force, with A at bits 1:0 and B at bits 3:2. Select 3 loads the reload mode from bits 7:6. A write takes effect at the clock edge.
- R9: Reset drives both pins low, clears both action words, sets shadow and active force to no force, and sets the reload mode to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Prescaled time-base tick |
| ev_zero | input | 1 | Counter at zero |
| ev_period | input | 1 | Counter at period |
| ev_cmpa_up | input | 1 | Compare A match while counting up |
| ev_cmpb_up | input | 1 | Compare B match while counting up |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select |
| wr_data | input | 10 | Write data |
| pwm_a | output | 1 | Channel A pin |
| pwm_b | output | 1 | Channel B pin |

## Verification
Two functions can fall on one tick: a reload of the override, and the event actions that the same zero or period strobe triggers. The bench leaves a force value in the shadow copy and then sends ticks that carry only a compare event, only period, and finally zero. It expects the pins to follow the event table until the selected reload event arrives. On that tick the pins must take the forced level at once. The reverse case is also tested: clearing the shadow and reloading it on period must hand the pin back to the event action on that same tick.

// File: rtl/pwm_action_stage.sv
module pwm_action_stage (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       ev_zero,
  input  logic       ev_period,
  input  logic       ev_cmpa_up,
  input  logic       ev_cmpb_up,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [9:0] wr_data,
  output logic       pwm_a,
  output logic       pwm_b
);
  localparam logic [1:0] SEL_ACT_A = 2'd0;
  localparam logic [1:0] SEL_ACT_B = 2'd1;
  localparam logic [1:0] SEL_FORCE = 2'd2;
  localparam logic [1:0] SEL_MODE  = 2'd3;

  // packed action word: [7:6] cmp B, [5:4] cmp A, [3:2] period, [1:0] zero
  logic [7:0] act_a, act_b;
  logic [3:0] frc_shadow, frc_active, frc_next;
  logic [1:0] reload_mode;
  logic       reload_now;

  function automatic logic step(input logic cur, input logic [1:0] code);
    case (code)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return ~cur;
      default: return cur;
    endcase
  endfunction

  function automatic logic resolve(input logic cur, input logic [7:0] w,
                                   input logic z, input logic p,
                                   input logic a, input logic b);
    logic v;
    v = cur;
    if (z) v = step(v, w[1:0]);
    if (p) v = step(v, w[3:2]);
    if (a) v = step(v, w[5:4]);
    if (b) v = step(v, w[7:6]);
    return v;
  endfunction

  function automatic logic apply_force(input logic evt, input logic [1:0] f);
    case (f)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      default: return evt;
    endcase
  endfunction

  always_comb begin
    case (reload_mode)
      2'b00:   reload_now = tick & ev_zero;
      2'b01:   reload_now = tick & ev_period;
      2'b10:   reload_now = tick & (ev_zero | ev_period);
      default: reload_now = 1'b1;
    endcase
  end

  assign frc_next = reload_now ? frc_shadow : frc_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_a       <= '0;
      act_b       <= '0;
      frc_shadow  <= '0;
      reload_mode <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_ACT_A: act_a       <= {wr_data[9:8], wr_data[5:0]};
        SEL_ACT_B: act_b       <= {wr_data[9:8], wr_data[5:0]};
        SEL_FORCE: frc_shadow  <= wr_data[3:0];
        SEL_MODE:  reload_mode <= wr_data[7:6];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frc_active <= '0;
      pwm_a      <= 1'b0;
      pwm_b      <= 1'b0;
    end else begin
      frc_active <= frc_next;
      if (tick) begin
        pwm_a <= apply_force(resolve(pwm_a, act_a, ev_zero, ev_period, ev_cmpa_up, ev_cmpb_up), frc_next[1:0]);
        pwm_b <= apply_force(resolve(pwm_b, act_b, ev_zero, ev_period, ev_cmpa_up, ev_cmpb_up), frc_next[3:2]);
      end
    end
  end
endmodule

// File: rtl/pwm_action_stage_chk.sv
module pwm_action_stage_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       ev_zero,
  input logic       ev_period,
  input logic       pwm_a,
  input logic       pwm_b,
  input logic [3:0] frc_next,
  input logic [3:0] frc_active,
  input logic [1:0] reload_mode
);
  assert_hold_without_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(pwm_a) && $stable(pwm_b)));

  assert_force_low_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && frc_next[1:0] == 2'b01) |=> !pwm_a);

  assert_force_high_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && frc_next[1:0] == 2'b10) |=> pwm_a);

  assert_force_low_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && frc_next[3:2] == 2'b01) |=> !pwm_b);

  assert_force_high_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && frc_next[3:2] == 2'b10) |=> pwm_b);

  assert_active_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_mode != 2'b11 && !(tick && (ev_zero || ev_period))) |=> $stable(frc_active));

  assert_reset_state_R9: assert property (@(posedge clk)
    !rst_n |=> (!pwm_a && !pwm_b && frc_active == 4'b0000));
endmodule

bind pwm_action_stage pwm_action_stage_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ev_zero(ev_zero), .ev_period(ev_period),
  .pwm_a(pwm_a), .pwm_b(pwm_b), .frc_next(frc_next), .frc_active(frc_active),
  .reload_mode(reload_mode)
);

// File: tb/test_pwm_action_stage.sv
module test_pwm_action_stage;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 34;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic ev_zero = 1'b0, ev_period = 1'b0, ev_cmpa_up = 1'b0, ev_cmpb_up = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [9:0] wr_data = '0;
  logic pwm_a, pwm_b;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_action_stage i_pwm_action_stage (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ev_zero(ev_zero), .ev_period(ev_period),
    .ev_cmpa_up(ev_cmpa_up), .ev_cmpb_up(ev_cmpb_up), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b));

  // {wr, sel, data16, tick, ev{cmpB,cmpA,period,zero}, exp_a, exp_b, req}
  localparam logic [29:0] VEC [NV] = '{
    {1'b1, 2'd0, 16'h001A, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd8}, // R8 normal A word
    {1'b1, 2'd1, 16'h010A, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd8}, // R8 normal B word
    {1'b0, 2'd0, 16'h0000, 1'b1, 4'b0001, 1'b1, 1'b1, 4'd2}, // R2 zero high
    {1'b0, 2'd0, 16'h0000, 1'b1, 4'b0100, 1'b0, 1'b1, 4'd1}, // R1 cmp A lowers A only
    {1'b0, 2'd0, 16'h0000, 1'b1, 4'b1000, 1'b0, 1'b0, 4'd1}, // R1 cmp B lowers B
    {1'b0, 2'd0, 16'h0000, 1'b1, 4'b0010, 1'b1, 1'b1, 4'd2}, // R2 period high
    {1'b0, 2'd0, 16'h0000, 1'b0, 4'b0101, 1'b1, 1'b1, 4'd3}, // R3 no tick
    {1'b0, 2'd0, 16'h0000, 1'b1, 4'b1101, 1'b0, 1'b0, 4'd4}, // R4 compare wins
    {1'b1, 2'd0, 16'h0025, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd2}, // R2 inverted A
    {1'b0, 2'd0, 16'h0000, 1'b1, 4'b0001, 1'b0, 1'b1, 4'd2}, // R2 inverted zero low
    {1'b0, 2'd0, 16'h0000, 1'b1, 4'b0100, 1'b1, 1'b1, 4'd2}, // R2 inverted cmp high
    {1'b1, 2'd0, 16'h003F, 1'b0, 4'b0000, 1'b1, 1'b1, 4'd2}, // R2 toggle word
    {1'b0, 2'd0, 16'h0000, 1'b1, 4'b0011, 1'b1, 1'b1, 4'd4}, // R4 double toggle
    {1'b0, 2'd0, 16'h0000, 1'b1, 4'b0001, 1'b0, 1'b1, 4'd2}, // R2 toggle
    {1'b1, 2'd2, 16'h0006, 1'b0, 4'b0000, 1'b0, 1'b1, 4'd6}, // R6 shadow only
    {1'b0, 2'd0, 16'h0000, 1'b1, 4'b0100, 1'b1, 1'b1, 4'd6}, // R6 no reload on cmp
    {1'b0, 2'd0, 16'h0000, 1'b1, 4'b0010, 1'b0, 1'b1, 4'd6}, // R6 no reload on period
    {1'b0, 2'd0, 16'h0000, 1'b1, 4'b0001, 1'b1, 1'b0, 4'd6}, // R6 reload at zero
    {1'b0, 2'd0, 16'h0000, 1'b1, 4'b1001, 1'b1, 1'b0, 4'd5}, // R5 events ignored
    {1'b1, 2'd2, 16'h0000, 1'b0, 4'b0000, 1'b1, 1'b0, 4'd6}, // R6 clear shadow
    {1'b0, 2'd0, 16'h0000, 1'b1, 4'b0010, 1'b1, 1'b0, 4'd6}, // R6 still forced
    {1'b1, 2'd3, 16'h0040, 1'b0, 4'b0000, 1'b1, 1'b0, 4'd6}, // R6 mode period
    {1'b0, 2'd0, 16'h0000, 1'b1, 4'b0010, 1'b0, 1'b1, 4'd6}, // R6 release on period
    {1'b1, 2'd3, 16'h00C0, 1'b0, 4'b0000, 1'b0, 1'b1, 4'd7}, // R7 immediate
    {1'b1, 2'd2, 16'h0006, 1'b0, 4'b0000, 1'b0, 1'b1, 4'd7}, // R7 write force
    {1'b0, 2'd0, 16'h0000, 1'b0, 4'b0000, 1'b0, 1'b1, 4'd7}, // R7 waits for tick
    {1'b0, 2'd0, 16'h0000, 1'b1, 4'b0000, 1'b1, 1'b0, 4'd7}, // R7 forced on tick
    {1'b1, 2'd2, 16'h000F, 1'b0, 4'b0000, 1'b1, 1'b0, 4'd5}, // R5 code 11
    {1'b0, 2'd0, 16'h0000, 1'b0, 4'b0000, 1'b1, 1'b0, 4'd5}, // R5 idle
    {1'b0, 2'd0, 16'h0000, 1'b1, 4'b0001, 1'b0, 1'b1, 4'd5}, // R5 11 does not force
    {1'b1, 2'd3, 16'h0080, 1'b0, 4'b0000, 1'b0, 1'b1, 4'd6}, // R6 mode either
    {1'b1, 2'd2, 16'h0009, 1'b0, 4'b0000, 1'b0, 1'b1, 4'd6}, // R6 shadow
    {1'b0, 2'd0, 16'h0000, 1'b1, 4'b0100, 1'b1, 1'b1, 4'd6}, // R6 no reload on cmp
    {1'b0, 2'd0, 16'h0000, 1'b1, 4'b0010, 1'b0, 1'b1, 4'd6}  // R6 reload on period
  };

  task automatic check(input logic ea, input logic eb, input string tag);
    checks++;
    if (pwm_a !== ea || pwm_b !== eb) begin
      errors++;
      $display("FAIL %s: pwm_a/pwm_b=%b%b expected %b%b", tag, pwm_a, pwm_b, ea, eb);
    end
  endtask

  task automatic drive(input logic w, input logic [1:0] s, input logic [9:0] d,
                       input logic t, input logic [3:0] ev);
    wr_en = w; wr_sel = s; wr_data = d; tick = t;
    {ev_cmpb_up, ev_cmpa_up, ev_period, ev_zero} = ev;
    @(posedge clk); @(negedge clk);
    wr_en = 0; tick = 0; {ev_cmpb_up, ev_cmpa_up, ev_period, ev_zero} = 4'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1'b0, 1'b0, "R9 reset outputs low");
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][29], VEC[i][28:27], VEC[i][20:11], VEC[i][10], VEC[i][9:6]);
      check(VEC[i][5], VEC[i][4], $sformatf("R%0d vector %0d", VEC[i][3:0], i));
    end
    // R9: reset clears a pending force and action words
    drive(1'b1, 2'd3, 10'h000, 1'b0, 4'b0000);
    drive(1'b1, 2'd2, 10'h005, 1'b0, 4'b0000);
    rst_n = 0;
    @(negedge clk);
    check(1'b0, 1'b0, "R9 reset mid-run");
    rst_n = 1;
    @(negedge clk);
    drive(1'b0, 2'd0, 10'h000, 1'b1, 4'b1111);
    check(1'b0, 1'b0, "R9 cleared action words");
    drive(1'b1, 2'd0, 10'h002, 1'b0, 4'b0000);
    drive(1'b1, 2'd1, 10'h002, 1'b0, 4'b0000);
    drive(1'b0, 2'd0, 10'h000, 1'b1, 4'b0001);
    check(1'b1, 1'b1, "R9 shadow force cleared");
    // R1: bits 7:6 of an action word are ignored
    drive(1'b1, 2'd0, 10'h0C0, 1'b0, 4'b0000);
    drive(1'b0, 2'd0, 10'h000, 1'b1, 4'b1111);
    check(1'b1, 1'b1, "R1 bits 7:6 ignored");
    finish_run();
  end
endmodule